// File: doc/BRIEF.md
# Receive lane synchronization tracker

This block follows character alignment and channel bonding for one deserialized receive lane. One character arrives on each clock. For each character the block receives several inputs: a strobe that marks a framing character, a flag that marks a valid character, a decoder-error flag and two fault inputs, one for elasticity-buffer underrun or overrun and one for receive PLL loss of lock. It also receives three bonding inputs: a bond-inhibit control, a master-channel-bonded indication and a deskew-window-expired pulse. The block drives its state, an in-sync flag and a 3-bit status code.

The state machine has four named states. The state encoding is S_HUNT=0, S_LOCK=1, S_REALIGN=2 and S_BONDED=3, and reset enters S_HUNT.

- Hunt to lock: a run of framing characters moves the lane from S_HUNT to S_LOCK.
- Lock or bonded to realign: while aligned, a single framing character starts a realignment attempt in S_REALIGN.
- Realign to bonded: the attempt completes into S_BONDED when a good character follows a framing character and the master channel has bonded.
- Drop to hunt: any loss condition sends the lane back to S_HUNT.
- Realign abort: an aborted attempt also sends the lane back to S_HUNT.

Loss of alignment is judged from two counters. One counts consecutive decoder errors. The other is a running count of invalid characters minus valid characters.

Top module: `rx_lane_sync`

## Requirements
- R1: After reset `state_o` is 0 (S_HUNT), `in_sync` is 0 and `status` is 3'b111.
- R2: In S_HUNT, four framing characters on four consecutive cycles move the lane to S_LOCK after the fourth one. Any cycle with `frm_det` low restarts the run.
- R3: In any state, `ebuf_fault` or `pll_unlock` forces S_HUNT on the next cycle. This takes priority over every other transition, including one caused by a framing character in the same cycle.
- R4: In S_LOCK or S_BONDED, four decoder errors on consecutive cycles return the lane to S_HUNT.
- R5: The loss count works as follows:
  - It rises by one on each character with `dec_err` high.
  - It falls by one on each character with `chr_ok` high and `dec_err` low, and does not go below 0.
  - It is cleared while the lane is in S_HUNT.
  - When it reaches 4 in S_LOCK or S_BONDED, the lane goes to S_HUNT.
- R6: In S_LOCK or S_BONDED, a framing character with no loss condition moves the lane to S_REALIGN.
- R7: In S_REALIGN, the lane goes to S_BONDED when all of the following hold in one cycle: the previous cycle had `frm_det` high, the current character has `chr_ok` high with `frm_det` and `dec_err` low, and `master_bonded` is high. If any of these is missing, the lane stays in S_REALIGN.
- R8: In S_REALIGN, the lane aborts to S_HUNT on either of these conditions:
  - `dec_err` is high;
  - `deskew_exp` is high while `bond_inh` is low or `master_bonded` is low.
- R9: `status` is registered together with the state and is chosen in this priority order:
  - 3'b111 when the new state is S_HUNT;
  - 3'b011 on the first cycle in S_BONDED;
  - 3'b101 for a framing character received in S_LOCK or S_BONDED;
  - 3'b010 for a decoder error received in S_LOCK or S_BONDED;
  - 3'b000 otherwise.
- R10: `in_sync` is high in every state except S_HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_det | input | 1 | Framing character on this cycle |
| chr_ok | input | 1 | A valid character is present on this cycle |
| dec_err | input | 1 | Decoder error on this cycle |
| ebuf_fault | input | 1 | Elasticity buffer underrun or overrun |
| pll_unlock | input | 1 | Receive PLL lost lock |
| bond_inh | input | 1 | Bond inhibit control |
| master_bonded | input | 1 | Master channel has bonded |
| deskew_exp | input | 1 | Deskew window expired |
| state_o | output | 2 | Current state (0 hunt, 1 lock, 2 realign, 3 bonded) |
| in_sync | output | 1 | Lane is aligned |
| status | output | 3 | Status code |

## Verification
Every result is registered, so the effect of a character appears on `state_o`, `in_sync` and `status` one clock after the rising edge that captures that character. The bench changes inputs at the falling edge and samples 1 ns after the next rising edge, so each check sees exactly one character's effect. Multi-character results are checked on the cycle they are due and also on the cycle before it. The results checked this way are the lock after four framing characters, the drop after four errors and the drop when the loss count reaches 4.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;
    typedef enum logic [1:0] {
        S_HUNT    = 2'd0,
        S_LOCK    = 2'd1,
        S_REALIGN = 2'd2,
        S_BONDED  = 2'd3
    } lane_state_t;

    localparam logic [2:0] ST_HUNT_CODE  = 3'b111;
    localparam logic [2:0] ST_BOND_CODE  = 3'b011;
    localparam logic [2:0] ST_FRAME_CODE = 3'b101;
    localparam logic [2:0] ST_ERR_CODE   = 3'b010;
    localparam logic [2:0] ST_IDLE_CODE  = 3'b000;
endpackage

// File: rtl/lane_run_counter.sv
module lane_run_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !hit) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = hit && !clr && (cnt == CW'(LIMIT - 1));

    // R2 / R4: a cycle without the event restarts the run
    p_run_break_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> cnt == '0);
endmodule

// File: rtl/lane_imv_counter.sv
module lane_imv_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic reach
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
        end else if (dec) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign reach = inc && !clr && (cnt == CW'(LIMIT - 1));

    // R5: the count floors at zero
    p_imv_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !inc) |=> cnt == '0);
endmodule

// File: rtl/rx_lane_sync.sv
module rx_lane_sync
    import rx_sync_pkg::*;
#(
    parameter int FRAME_RUN = 4,
    parameter int ERR_RUN   = 4,
    parameter int IMV_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_det,
    input  logic       chr_ok,
    input  logic       dec_err,
    input  logic       ebuf_fault,
    input  logic       pll_unlock,
    input  logic       bond_inh,
    input  logic       master_bonded,
    input  logic       deskew_exp,
    output logic [1:0] state_o,
    output logic       in_sync,
    output logic [2:0] status
);
    lane_state_t state, nxt;
    logic        prev_frm;
    logic        frm_last, err_last, imv_reach;
    logic        fault, skew_abort, good_chr, aligned;

    assign fault      = ebuf_fault | pll_unlock;
    assign skew_abort = deskew_exp & (~bond_inh | ~master_bonded);
    assign good_chr   = chr_ok & ~dec_err & ~frm_det;
    assign aligned    = (state == S_LOCK) || (state == S_BONDED);

    lane_run_counter #(.LIMIT(FRAME_RUN)) u_frm_run (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != S_HUNT),
        .hit  (frm_det),
        .last (frm_last)
    );

    lane_run_counter #(.LIMIT(ERR_RUN)) u_err_run (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == S_HUNT),
        .hit  (dec_err),
        .last (err_last)
    );

    lane_imv_counter #(.LIMIT(IMV_LIMIT)) u_imv (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == S_HUNT),
        .inc  (dec_err),
        .dec  (chr_ok & ~dec_err),
        .reach(imv_reach)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_HUNT: begin
                if (frm_last && !fault) nxt = S_LOCK;
            end
            S_LOCK, S_BONDED: begin
                if (fault)                      nxt = S_HUNT;
                else if (err_last || imv_reach) nxt = S_HUNT;
                else if (frm_det)               nxt = S_REALIGN;
            end
            S_REALIGN: begin
                if (fault || dec_err || skew_abort)          nxt = S_HUNT;
                else if (prev_frm && good_chr && master_bonded) nxt = S_BONDED;
            end
            default: nxt = S_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_HUNT;
            prev_frm <= 1'b0;
        end else begin
            state    <= nxt;
            prev_frm <= frm_det;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= ST_HUNT_CODE;
        end else if (nxt == S_HUNT) begin
            status <= ST_HUNT_CODE;
        end else if (nxt == S_BONDED && state != S_BONDED) begin
            status <= ST_BOND_CODE;
        end else if (aligned && frm_det) begin
            status <= ST_FRAME_CODE;
        end else if (aligned && dec_err) begin
            status <= ST_ERR_CODE;
        end else begin
            status <= ST_IDLE_CODE;
        end
    end

    assign state_o = state;
    assign in_sync = (state != S_HUNT);

    p_fault_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> state == S_HUNT);

    p_hunt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HUNT && !frm_det) |=> state == S_HUNT);

    p_abort_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REALIGN && dec_err) |=> state == S_HUNT);

    p_hunt_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_HUNT |-> status == ST_HUNT_CODE);

    p_bond_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BONDED && $past(state) != S_BONDED) |-> status == ST_BOND_CODE);
endmodule

// File: tb/rx_lane_sync_test.sv
module rx_lane_sync_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_det = 0, chr_ok = 0, dec_err = 0;
    logic       ebuf_fault = 0, pll_unlock = 0;
    logic       bond_inh = 1, master_bonded = 1, deskew_exp = 0;
    logic [1:0] state_o;
    logic       in_sync;
    logic [2:0] status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_lane_sync uut (
        .clk(clk), .rst_n(rst_n), .frm_det(frm_det), .chr_ok(chr_ok),
        .dec_err(dec_err), .ebuf_fault(ebuf_fault), .pll_unlock(pll_unlock),
        .bond_inh(bond_inh), .master_bonded(master_bonded),
        .deskew_exp(deskew_exp), .state_o(state_o), .in_sync(in_sync),
        .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input int st, input int code);
        chk({tag, " state"}, state_o, st);
        chk({tag, " status"}, status, code);
        chk({tag, " in_sync (R10)"}, in_sync, (st != 0) ? 1 : 0);
    endtask

    task automatic put(input logic f, input logic ok, input logic e);
        @(negedge clk);
        frm_det = f; chr_ok = ok; dec_err = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        frm_det = 0; chr_ok = 0; dec_err = 0; ebuf_fault = 0; pll_unlock = 0;
        bond_inh = 1; master_bonded = 1; deskew_exp = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
    endtask

    task automatic go_lock();
        repeat (4) put(1, 1, 0);
        put(0, 1, 0);
    endtask

    task automatic t_reset();
        do_reset();
        look("R1 reset", 0, 7);
    endtask

    task automatic t_lock();
        do_reset();
        put(1, 1, 0); put(1, 1, 0); put(1, 1, 0);
        put(0, 1, 0);
        look("R2 broken run", 0, 7);
        put(1, 1, 0); put(1, 1, 0); put(1, 1, 0);
        look("R2 three frames", 0, 7);
        put(1, 1, 0);
        look("R2 fourth frame locks", 1, 0);
    endtask

    task automatic t_fault();
        do_reset();
        go_lock();
        pll_unlock = 1;
        put(1, 1, 0);
        pll_unlock = 0;
        look("R3 pll over frame", 0, 7);
        go_lock();
        ebuf_fault = 1;
        put(0, 1, 0);
        ebuf_fault = 0;
        look("R3 buffer fault", 0, 7);
    endtask

    task automatic t_err_run();
        do_reset();
        go_lock();
        put(0, 0, 1); put(0, 0, 1); put(0, 0, 1);
        look("R4 R9 three errors", 1, 2);
        put(0, 0, 1);
        look("R4 fourth error", 0, 7);
    endtask

    task automatic t_imv();
        do_reset();
        go_lock();
        put(0, 0, 1); put(0, 0, 1); put(0, 1, 0); put(0, 0, 1); put(0, 0, 1);
        look("R5 count three", 1, 2);
        put(0, 0, 1);
        look("R5 count four", 0, 7);
        go_lock();
        repeat (5) put(0, 1, 0);
        put(0, 0, 1); put(0, 0, 1); put(0, 0, 1); put(0, 1, 0); put(0, 0, 1);
        look("R5 floor then three", 1, 2);
        put(0, 0, 1);
        look("R5 floor then four", 0, 7);
    endtask

    task automatic t_resync();
        do_reset();
        go_lock();
        put(1, 1, 0);
        look("R6 R9 frame starts realign", 2, 5);
        put(0, 1, 0);
        look("R7 R9 bonded entry", 3, 3);
        put(0, 1, 0);
        look("R9 bonded idle", 3, 0);
        put(0, 0, 1);
        look("R9 bonded error", 3, 2);
        put(1, 1, 0);
        look("R6 bonded frame", 2, 5);
    endtask

    task automatic t_nobond();
        do_reset();
        go_lock();
        put(1, 1, 0);
        master_bonded = 0;
        put(0, 1, 0);
        master_bonded = 1;
        look("R7 master not bonded", 2, 0);
        put(0, 1, 0);
        look("R7 no frame before", 2, 0);
        put(1, 1, 0);
        put(0, 1, 0);
        look("R7 bond after frame", 3, 3);
    endtask

    task automatic t_abort();
        do_reset();
        go_lock();
        put(1, 1, 0);
        deskew_exp = 1;
        put(0, 0, 0);
        look("R8 deskew inhibited", 2, 0);
        bond_inh = 0;
        put(0, 0, 0);
        deskew_exp = 0; bond_inh = 1;
        look("R8 deskew abort", 0, 7);
        go_lock();
        put(1, 1, 0);
        put(0, 0, 1);
        look("R8 error abort", 0, 7);
    endtask

    initial begin
        t_reset();
        t_lock();
        t_fault();
        t_err_run();
        t_imv();
        t_resync();
        t_nobond();
        t_abort();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule